// File: doc/BRIEF.md
# Read Data Lane Steering Packer

This block sits on the read path of an external memory controller. Each read word arrives from a 32-bit memory data bus. The block first picks the live data lane for the chip select that owns the access. That lane is either the full 32-bit bus, or the lower or upper 16-bit half of it. The block then assembles one or more such words into a result of 8, 16, 32 or 64 bits, right-aligned in a 64-bit output. Each chip select has its own 3-bit configuration field. A 16-bit device and a 32-bit device can therefore share the bus, each with its own lane and packing width.

The packer is a two-state machine. In `ST_IDLE` no partial result is held. In `ST_FILL` some words of a multi-word result have been stored. The transitions are:

- **start** (`ST_IDLE` to `ST_FILL`): a word arrives that does not finish its result.
- **complete** (`ST_FILL` to `ST_IDLE`): the last word arrives.
- **direct** (`ST_IDLE` to `ST_IDLE`): a single word finishes a result on its own.
- **accumulate** (`ST_FILL` to `ST_FILL`): a middle word arrives.
- **restart** (`ST_FILL` to `ST_FILL` or `ST_IDLE`): a word comes from a different chip select. The stored partial result is dropped, an error pulse is raised, and the new word begins a fresh result.

The access size and byte order are captured from the first word of each result.

Top module: `rd_lane_packer`

## Requirements
- R1: After reset, `out_valid` and `cs_err` are low and `out_data` is all zeros.
- R2: The field for chip select 0 is `cs_cfg[2:0]` and the field for chip select 1 is `cs_cfg[5:3]`. Value 000 selects the lower 16 bits of `in_data` (bits 15:0). Value 001 selects the upper 16 bits (bits 31:16). Any value with bit 1 or bit 2 set selects the full 32-bit bus.
- R3: `req_size` encodes the result width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The number of words needed is the result width divided by the lane width (16 or 32), with a minimum of one.
- R4: With `big_endian` low, the first word of a multi-word result fills the least significant lane-width slot, and each later word fills the next slot up.
- R5: With `big_endian` high, the first word of a multi-word result fills the most significant slot of the result width, and each later word fills the next slot down.
- R6: For an 8-bit result, the byte index is `byte_addr[1:0]` on a 32-bit lane and `byte_addr[0]` on a 16-bit lane. Byte i is bits 8i+7 down to 8i of the steered word. The result is zero-extended to 64 bits.
- R7: For a 16-bit result on a 32-bit lane, `byte_addr[1]` picks the upper half (1) or the lower half (0). A 32-bit result on a 32-bit lane is the whole word in one beat.
- R8: `out_valid` pulses for exactly one cycle, in the cycle after the completing word is accepted. Words that do not complete a result produce no pulse. Result bits above the requested width are zero.
- R9: The size and byte order given with the first word of a result are used for the whole result. Different values given with later words of the same result are ignored.
- R10: If a word arrives from a different chip select while a partial result is held, the partial result is discarded and `cs_err` pulses for one cycle, in the cycle after that word. The word then starts a new result. When that word completes a result on its own, `out_valid` pulses in the same cycle as `cs_err`.
- R11: Cycles with `in_valid` low leave a partial result unchanged. Assembly resumes with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_cfg | input | 6 | Lane configuration fields, 3 bits per chip select |
| in_valid | input | 1 | A read word is present on `in_data` |
| in_cs | input | 1 | Chip select that owns the word |
| in_data | input | 32 | Raw memory data bus |
| req_size | input | 2 | Requested result width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| big_endian | input | 1 | 1 = first word goes to the most significant slot |
| byte_addr | input | 2 | Low address bits for narrow results |
| out_valid | output | 1 | One-cycle pulse when a packed result is ready |
| out_data | output | 64 | Packed result, right-aligned |
| cs_err | output | 1 | One-cycle pulse when a partial result is dropped |

## Verification
Two events can land in the same cycle: the error pulse for a dropped partial result, and the completion of a new result. A 64-bit assembly on chip select 0 is left half done. Then a single 32-bit word is sent from chip select 1, which is configured for the full bus. That word both aborts the old result and completes a new one. The bench expects `cs_err` and `out_valid` high together, and `out_data` to hold only the new word with no trace of the discarded halves. A second case aborts with a word that does not complete a result. There the bench expects the error pulse alone, followed by a correct result from the new chip select.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } rdp_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } rdp_state_e;

    // Words needed for one result: width / lane width, at least one.
    function automatic logic [2:0] words_needed(rdp_size_e sz, logic wide, int bus_w);
        int bits;
        int lane;
        bits = 8 << sz;
        lane = wide ? bus_w : bus_w / 2;
        return (bits <= lane) ? 3'd1 : 3'(bits / lane);
    endfunction

endpackage

// File: rtl/rdp_lane_steer.sv
module rdp_lane_steer #(
    parameter int BUS_W  = 32,
    parameter int NUM_CS = 2,
    parameter int FLD_W  = 3,
    localparam int HALF_W = BUS_W / 2,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*FLD_W-1:0] cs_cfg,
    input  logic [CS_W-1:0]         cs,
    input  logic [BUS_W-1:0]        bus,
    output logic [BUS_W-1:0]        word,
    output logic                    wide
);

    logic [FLD_W-1:0] fld [NUM_CS];
    logic [FLD_W-1:0] sel;

    // One field per chip select
    for (genvar c = 0; c < NUM_CS; c++) begin : g_fld
        assign fld[c] = cs_cfg[c*FLD_W +: FLD_W];
    end

    always_comb begin
        sel  = fld[cs];
        wide = |sel[FLD_W-1:1];
        if (wide) begin
            word = bus;
        end else if (sel[0]) begin
            word = {{HALF_W{1'b0}}, bus[BUS_W-1:HALF_W]};
        end else begin
            word = {{HALF_W{1'b0}}, bus[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/rdp_narrow_pick.sv
module rdp_narrow_pick
    import rdp_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int HALF_W = BUS_W / 2,
    localparam int AW     = $clog2(BUS_W / 8)
) (
    input  logic [BUS_W-1:0] word,
    input  logic             wide,
    input  rdp_size_e        size,
    input  logic [AW-1:0]    addr,
    output logic [BUS_W-1:0] res
);

    logic [AW-1:0]    idx;
    logic [BUS_W-1:0] sh;

    always_comb begin
        idx = '0;
        sh  = word;
        res = word;
        unique case (size)
            SZ8: begin
                idx = wide ? addr : {{(AW-1){1'b0}}, addr[0]};
                sh  = word >> (idx * 8);
                res = {{(BUS_W-8){1'b0}}, sh[7:0]};
            end
            SZ16: begin
                if (wide && addr[AW-1]) begin
                    res = {{HALF_W{1'b0}}, word[BUS_W-1:HALF_W]};
                end else begin
                    res = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
                end
            end
            default: res = word;
        endcase
    end

endmodule

// File: rtl/rdp_slot_place.sv
module rdp_slot_place #(
    parameter int BUS_W = 32,
    parameter int OUT_W = 64,
    localparam int HALF_W = BUS_W / 2,
    localparam int SLOT_W = 3
) (
    input  logic [BUS_W-1:0]  word,
    input  logic              wide,
    input  logic [SLOT_W-1:0] slot,
    output logic [OUT_W-1:0]  placed
);

    logic [OUT_W-1:0] ext_full;
    logic [OUT_W-1:0] ext_half;

    always_comb begin
        ext_full = {{(OUT_W-BUS_W){1'b0}}, word};
        ext_half = {{(OUT_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
        if (wide) begin
            placed = ext_full << (slot * BUS_W);
        end else begin
            placed = ext_half << (slot * HALF_W);
        end
    end

endmodule

// File: rtl/rd_lane_packer.sv
module rd_lane_packer
    import rdp_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int OUT_W  = 64,
    parameter int NUM_CS = 2,
    parameter int FLD_W  = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int AW    = $clog2(BUS_W / 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*FLD_W-1:0] cs_cfg,
    input  logic                    in_valid,
    input  logic [CS_W-1:0]         in_cs,
    input  logic [BUS_W-1:0]        in_data,
    input  logic [1:0]              req_size,
    input  logic                    big_endian,
    input  logic [AW-1:0]           byte_addr,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data,
    output logic                    cs_err
);

    rdp_state_e       state_q, state_d;
    logic [2:0]       cnt_q;
    logic [OUT_W-1:0] acc_q;
    rdp_size_e        lat_size;
    logic             lat_be;
    logic [CS_W-1:0]  lat_cs;

    logic [BUS_W-1:0] steer_word;
    logic             wide;
    logic [BUS_W-1:0] narrow;
    logic [OUT_W-1:0] placed;

    logic             switch_cs, first, done, eff_be;
    rdp_size_e        eff_size;
    logic [2:0]       need, idx, slot;
    logic [OUT_W-1:0] base, acc_d;

    rdp_lane_steer #(.BUS_W(BUS_W), .NUM_CS(NUM_CS), .FLD_W(FLD_W)) u_steer (
        .cs_cfg (cs_cfg),
        .cs     (in_cs),
        .bus    (in_data),
        .word   (steer_word),
        .wide   (wide)
    );

    rdp_narrow_pick #(.BUS_W(BUS_W)) u_pick (
        .word (steer_word),
        .wide (wide),
        .size (eff_size),
        .addr (byte_addr),
        .res  (narrow)
    );

    rdp_slot_place #(.BUS_W(BUS_W), .OUT_W(OUT_W)) u_place (
        .word   (steer_word),
        .wide   (wide),
        .slot   (slot),
        .placed (placed)
    );

    // Next state and datapath decisions
    always_comb begin
        switch_cs = (state_q == ST_FILL) && (in_cs != lat_cs);
        first     = (state_q == ST_IDLE) || switch_cs;
        eff_size  = first ? rdp_size_e'(req_size) : lat_size;
        eff_be    = first ? big_endian : lat_be;
        need      = words_needed(eff_size, wide, BUS_W);
        idx       = first ? 3'd0 : cnt_q;
        slot      = eff_be ? (need - 3'd1 - idx) : idx;
        base      = first ? '0 : acc_q;
        acc_d     = (need == 3'd1) ? {{(OUT_W-BUS_W){1'b0}}, narrow} : (base | placed);
        done      = in_valid && ((idx + 3'd1) == need);

        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid && !done) state_d = ST_FILL;
            ST_FILL: if (done)              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Accumulator, captured attributes and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            lat_size  <= SZ8;
            lat_be    <= 1'b0;
            lat_cs    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            cs_err    <= 1'b0;
        end else begin
            out_valid <= done;
            cs_err    <= in_valid && switch_cs;
            if (done) begin
                out_data <= acc_d;
            end
            if (in_valid) begin
                acc_q <= acc_d;
                cnt_q <= done ? 3'd0 : (idx + 3'd1);
                if (first) begin
                    lat_size <= eff_size;
                    lat_be   <= eff_be;
                    lat_cs   <= in_cs;
                end
            end
        end
    end

endmodule

// File: rtl/rdp_chk.sv
module rdp_chk #(
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       req_size,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             cs_err,
    input logic             st_idle,
    input logic [2:0]       cnt_q
);

    // R8
    valid_from_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R10
    err_needs_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_err |-> ($past(in_valid) && !$past(st_idle)));

    // R11
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && !in_valid) |=> $stable(cnt_q));

    // R6
    byte_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_idle && req_size == 2'd0) |=> (out_valid && out_data[OUT_W-1:8] == '0));

    // R3
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> (cnt_q == 3'd0));

endmodule

bind rd_lane_packer rdp_chk #(.OUT_W(OUT_W)) i_rdp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .req_size  (req_size),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cs_err    (cs_err),
    .st_idle   (state_q == rdp_pkg::ST_IDLE),
    .cnt_q     (cnt_q)
);

// File: tb/test_rd_lane_packer.sv
`timescale 1ns/1ps
module test_rd_lane_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cs_cfg = 6'b010_000;
    logic        in_valid = 1'b0;
    logic [0:0]  in_cs = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  req_size = '0;
    logic        big_endian = 1'b0;
    logic [1:0]  byte_addr = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        cs_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rd_lane_packer i_rd_lane_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_cfg     (cs_cfg),
        .in_valid   (in_valid),
        .in_cs      (in_cs),
        .in_data    (in_data),
        .req_size   (req_size),
        .big_endian (big_endian),
        .byte_addr  (byte_addr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .cs_err     (cs_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one word; returns just after the edge that takes it
    task automatic beat(input logic cs, input logic [31:0] d, input logic [1:0] sz,
                        input logic be, input logic [1:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_cs = cs; in_data = d;
        req_size = sz; big_endian = be; byte_addr = a;
        @(posedge clk); #1;
    endtask

    // One idle cycle, sampled after its edge
    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hFFFF_FFFF;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 cs_err", {63'd0, cs_err}, 64'd0);
        chk("R1 out_data", out_data, 64'd0);
    endtask

    task automatic t_le16();
        cs_cfg = 6'b010_000;
        beat(1'b0, 32'hDEAD_1111, 2'd3, 1'b0, 2'd0);
        chk("R8 no pulse mid", {63'd0, out_valid}, 64'd0);
        beat(1'b0, 32'hDEAD_2222, 2'd3, 1'b0, 2'd0);
        beat(1'b0, 32'hDEAD_3333, 2'd3, 1'b0, 2'd0);
        chk("R8 no pulse mid3", {63'd0, out_valid}, 64'd0);
        beat(1'b0, 32'hDEAD_4444, 2'd3, 1'b0, 2'd0);
        chk("R4 valid", {63'd0, out_valid}, 64'd1);
        chk("R4 le 16x4", out_data, 64'h4444_3333_2222_1111);
        gap();
        chk("R8 one-cycle pulse", {63'd0, out_valid}, 64'd0);
        chk("R8 data held", out_data, 64'h4444_3333_2222_1111);
    endtask

    task automatic t_be16();
        beat(1'b0, 32'hBEEF_1111, 2'd3, 1'b1, 2'd0);
        beat(1'b0, 32'hBEEF_2222, 2'd3, 1'b1, 2'd0);
        beat(1'b0, 32'hBEEF_3333, 2'd3, 1'b1, 2'd0);
        beat(1'b0, 32'hBEEF_4444, 2'd3, 1'b1, 2'd0);
        chk("R5 be 16x4", out_data, 64'h1111_2222_3333_4444);
        beat(1'b0, 32'h0000_AAAA, 2'd2, 1'b1, 2'd0);
        beat(1'b0, 32'h0000_BBBB, 2'd2, 1'b1, 2'd0);
        chk("R5 be 16x2 zero upper", out_data, 64'h0000_0000_AAAA_BBBB);
        gap();
    endtask

    task automatic t_wide32();
        beat(1'b1, 32'hAAAA_0001, 2'd3, 1'b0, 2'd0);
        beat(1'b1, 32'hBBBB_0002, 2'd3, 1'b0, 2'd0);
        chk("R4 le 32x2", out_data, 64'hBBBB_0002_AAAA_0001);
        beat(1'b1, 32'hAAAA_0001, 2'd3, 1'b1, 2'd0);
        beat(1'b1, 32'hBBBB_0002, 2'd3, 1'b1, 2'd0);
        chk("R5 be 32x2", out_data, 64'hAAAA_0001_BBBB_0002);
        beat(1'b1, 32'hCAFE_BEEF, 2'd2, 1'b0, 2'd0);
        chk("R3 32 in one word", out_data, 64'h0000_0000_CAFE_BEEF);
        gap();
    endtask

    task automatic t_upper();
        cs_cfg = 6'b010_001;
        beat(1'b0, 32'h5678_FFFF, 2'd2, 1'b0, 2'd0);
        beat(1'b0, 32'h1234_EEEE, 2'd2, 1'b0, 2'd0);
        chk("R2 upper half lane", out_data, 64'h0000_0000_1234_5678);
        cs_cfg = 6'b110_000;
        beat(1'b1, 32'h1357_9BDF, 2'd2, 1'b0, 2'd0);
        chk("R2 bit2 means 32-bit", out_data, 64'h0000_0000_1357_9BDF);
        cs_cfg = 6'b010_000;
        gap();
    endtask

    task automatic t_narrow();
        beat(1'b1, 32'h4433_2211, 2'd0, 1'b0, 2'd2);
        chk("R6 byte 2 of 32", out_data, 64'h33);
        beat(1'b0, 32'h7766_9988, 2'd0, 1'b0, 2'd3);
        chk("R6 byte 1 of 16", out_data, 64'h99);
        beat(1'b1, 32'hCAFE_BEEF, 2'd1, 1'b0, 2'd2);
        chk("R7 upper half of 32", out_data, 64'hCAFE);
        beat(1'b1, 32'hCAFE_BEEF, 2'd1, 1'b0, 2'd0);
        chk("R7 lower half of 32", out_data, 64'hBEEF);
        chk("R7 back-to-back valid", {63'd0, out_valid}, 64'd1);
        gap();
    endtask

    task automatic t_latch();
        beat(1'b0, 32'h0000_0001, 2'd2, 1'b0, 2'd0);
        beat(1'b0, 32'h0000_0002, 2'd3, 1'b1, 2'd0);
        chk("R9 done after 2", {63'd0, out_valid}, 64'd1);
        chk("R9 first attrs kept", out_data, 64'h0000_0000_0002_0001);
        gap();
    endtask

    task automatic t_gap();
        beat(1'b0, 32'h0000_00AA, 2'd2, 1'b0, 2'd0);
        gap(); gap(); gap();
        chk("R11 no pulse in gap", {63'd0, out_valid}, 64'd0);
        beat(1'b0, 32'h0000_00BB, 2'd2, 1'b0, 2'd0);
        chk("R11 resumed", out_data, 64'h0000_0000_00BB_00AA);
        gap();
    endtask

    task automatic t_switch();
        beat(1'b0, 32'h0000_1111, 2'd3, 1'b0, 2'd0);
        beat(1'b0, 32'h0000_2222, 2'd3, 1'b0, 2'd0);
        beat(1'b1, 32'h600D_F00D, 2'd2, 1'b0, 2'd0);
        chk("R10 err pulse", {63'd0, cs_err}, 64'd1);
        chk("R10 valid same cycle", {63'd0, out_valid}, 64'd1);
        chk("R10 only new word", out_data, 64'h0000_0000_600D_F00D);
        gap();
        chk("R10 err one cycle", {63'd0, cs_err}, 64'd0);
        beat(1'b1, 32'h0000_0001, 2'd3, 1'b0, 2'd0);
        beat(1'b0, 32'h0000_000A, 2'd2, 1'b0, 2'd0);
        chk("R10 err no valid", {62'd0, cs_err, out_valid}, 64'd2);
        beat(1'b0, 32'h0000_000B, 2'd2, 1'b0, 2'd0);
        chk("R10 new result", out_data, 64'h0000_0000_000B_000A);
        chk("R10 err cleared", {62'd0, cs_err, out_valid}, 64'd1);
        gap();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_le16();
        t_be16();
        t_wide32();
        t_upper();
        t_narrow();
        t_latch();
        t_gap();
        t_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule